// File: doc/BRIEF.md
# Indirect Interrupt Routing Table Register Window

This block is the software-facing register interface of an I/O interrupt controller. Only two registers are visible on the bus. One is an 8-bit pointer, and the other is a 32-bit data port. The pointer selects what the data port reaches: a small identifier register, a fixed version word, or one half of a 64-bit routing entry. There is one routing entry per interrupt input pin. Each entry holds a vector, a delivery mode, a destination mode, a polarity, a trigger mode, a mask bit and a destination.

Two bits of each entry belong to the delivery hardware and not to software: the delivery-status bit and the remote-IRR bit. Bus writes never change them. The delivery logic updates them through a dedicated status port. Whenever a bus write leaves an entry in edge mode, its remote-IRR bit is cleared. Whenever a bus write flips an entry's mask bit, the block emits a one-cycle notification carrying that entry's index.

Top module: `irq_regwin`

## Requirements
- R1: Bus offset 0x00 is the pointer register and offset 0x10 is the data port. A read at any other offset returns zero, and a write at any other offset changes nothing.
- R2: The pointer register is 8 bits wide, resets to 0, stores bits 7:0 of the write data, and reads back zero-extended.
- R3: With the pointer at 0x01, the data port reads {8'h00, NUM_PINS-1, 8'h00, VERSION_ID}, which is 32'h0017_0020 by default. Writes at that pointer value are ignored.
- R4: With the pointer at 0x00, the data port reaches a 4-bit identifier in bits 27:24, and all other bits read as zero. With the pointer at 0x02, the data port reads the same value, and writes there are ignored.
- R5: A pointer value p of 0x10 or above selects entry (p-0x10)>>1. An even p reaches bits 31:0 and an odd p reaches bits 63:32. A write to one half leaves the other half unchanged.
- R6: Pointer values 0x03 to 0x0F, and pointer values whose entry index is NUM_PINS or more (0x40 and above by default), read as 32'hFFFF_FFFF. Writes at those pointer values change nothing.
- R7: A bus write to an entry keeps that entry's delivery-status bit (bit 12) and remote-IRR bit (bit 14), whatever the write data holds.
- R8: After any bus write to an entry, if the entry's trigger bit (bit 15) is 0 (edge), its remote-IRR bit is 0.
- R9: After reset, every entry reads 64'h0000_0000_0001_0000, with only the mask bit (bit 16) set. The identifier is also 0.
- R10: `req_ready` is always 1. Every accepted request gives `rsp_valid` high for exactly the next cycle, with registered read data (zero for writes).
- R11: When a bus write changes an entry's mask bit, `mask_chg_valid` pulses for one cycle, in the cycle after the write, with `mask_chg_idx` set to that entry's index. No other write causes the pulse.
- R12: A `sts_wr` cycle loads bits 12 and 14 of entry `sts_idx` from `sts_dstat` and `sts_rirr`. When it hits the same entry as a bus write in the same cycle, the status port's values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the block |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Registered read data |
| sts_wr | input | 1 | Status update strobe from the delivery logic |
| sts_idx | input | IDX_W (5) | Entry index for the status update |
| sts_rirr | input | 1 | New remote-IRR value |
| sts_dstat | input | 1 | New delivery-status value |
| mask_chg_valid | output | 1 | Mask-change notification pulse |
| mask_chg_idx | output | IDX_W (5) | Index of the entry whose mask changed |

## Verification
The assertions check several rules on every cycle:
- The response strobe follows each accepted request by exactly one cycle.
- A pointer write captures the low data byte.
- Reads through the data port at invalid pointer values return all ones.
- A write at the arbitration pointer leaves the identifier untouched.
- After each bus write to an entry, the delivery-status bit has its old value and an edge entry has remote-IRR clear.
- Every mask notification is preceded by a bus write.

The bench scenarios cover what needs a history of writes:
- The two halves of an entry are independent.
- The identifier reads back through both aliases.
- Ignored writes really do leave the version word and the pointer unchanged.
- A status bit set by the hardware survives a software rewrite.
- The status port wins over a same-cycle bus write.
- Every entry comes out of reset masked.

// File: rtl/irq_regwin_pkg.sv
package irq_regwin_pkg;

  localparam int BIT_DSTAT = 12;
  localparam int BIT_RIRR  = 14;
  localparam int BIT_TRIG  = 15;
  localparam int BIT_MASK  = 16;

  localparam logic [63:0] ENTRY_RST = 64'h1 << BIT_MASK;

  localparam logic [7:0] OFF_PTR  = 8'h00;
  localparam logic [7:0] OFF_DATA = 8'h10;

  typedef enum logic [2:0] {
    TGT_ID,
    TGT_VER,
    TGT_ARB,
    TGT_ENTRY,
    TGT_NONE
  } tgt_e;

endpackage

// File: rtl/irq_regwin_decode.sv
module irq_regwin_decode
  import irq_regwin_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic [7:0]       ptr,
  output tgt_e             tgt,
  output logic [IDX_W-1:0] idx,
  output logic             hi
);

  logic [6:0] eidx;
  assign eidx = ptr[7:1] - 7'h08;
  assign hi   = ptr[0];
  assign idx  = eidx[IDX_W-1:0];

  always_comb begin
    if (ptr == 8'h00)                               tgt = TGT_ID;
    else if (ptr == 8'h01)                          tgt = TGT_VER;
    else if (ptr == 8'h02)                          tgt = TGT_ARB;
    else if (ptr >= 8'h10 && int'(eidx) < NUM_PINS) tgt = TGT_ENTRY;
    else                                            tgt = TGT_NONE;
  end

endmodule

// File: rtl/irq_regwin_table.sv
module irq_regwin_table
  import irq_regwin_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_hi,
  input  logic [31:0]      wr_data,
  input  logic             sts_wr,
  input  logic [IDX_W-1:0] sts_idx,
  input  logic             sts_rirr,
  input  logic             sts_dstat,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_hi,
  output logic [31:0]      rd_half,
  output logic             mask_chg_valid,
  output logic [IDX_W-1:0] mask_chg_idx
);

  logic [63:0] ent_q [NUM_PINS];
  logic [63:0] ent_d [NUM_PINS];

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    always_comb begin
      ent_d[g] = ent_q[g];
      if (wr_en && wr_idx == IDX_W'(g)) begin
        if (wr_hi) ent_d[g][63:32] = wr_data;
        else       ent_d[g][31:0]  = wr_data;
        ent_d[g][BIT_DSTAT] = ent_q[g][BIT_DSTAT];
        ent_d[g][BIT_RIRR]  = ent_q[g][BIT_RIRR];
        if (!ent_d[g][BIT_TRIG]) ent_d[g][BIT_RIRR] = 1'b0;
      end
      if (sts_wr && sts_idx == IDX_W'(g)) begin
        ent_d[g][BIT_RIRR]  = sts_rirr;
        ent_d[g][BIT_DSTAT] = sts_dstat;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) ent_q[g] <= ENTRY_RST;
      else     ent_q[g] <= ent_d[g];
    end
  end

  assign rd_half = rd_hi ? ent_q[rd_idx][63:32] : ent_q[rd_idx][31:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_chg_valid <= 1'b0;
      mask_chg_idx   <= '0;
    end else begin
      mask_chg_valid <= wr_en && !wr_hi &&
                        (wr_data[BIT_MASK] != ent_q[wr_idx][BIT_MASK]);
      mask_chg_idx   <= wr_idx;
    end
  end

  // R7: hardware-owned delivery status survives a bus write
  assert_dstat_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(sts_wr && sts_idx == wr_idx)) |=>
      ent_q[$past(wr_idx)][BIT_DSTAT] == $past(ent_q[wr_idx][BIT_DSTAT]));

  // R8: an edge entry never holds remote-IRR after a bus write
  assert_edge_rirr_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(sts_wr && sts_idx == wr_idx)) |=>
      (ent_q[$past(wr_idx)][BIT_TRIG] || !ent_q[$past(wr_idx)][BIT_RIRR]));

  // R11: a mask notification always stems from a bus write
  assert_mask_pulse_src_R11: assert property (@(posedge clk) disable iff (rst)
    mask_chg_valid |-> $past(wr_en));

endmodule

// File: rtl/irq_regwin.sv
module irq_regwin
  import irq_regwin_pkg::*;
#(
  parameter int         NUM_PINS   = 24,
  parameter logic [7:0] VERSION_ID = 8'h20,
  parameter int         IDX_W      = $clog2(NUM_PINS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [7:0]       req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  input  logic             sts_wr,
  input  logic [IDX_W-1:0] sts_idx,
  input  logic             sts_rirr,
  input  logic             sts_dstat,
  output logic             mask_chg_valid,
  output logic [IDX_W-1:0] mask_chg_idx
);

  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION_ID};

  logic [7:0]       ptr_q;
  logic [3:0]       id_q;
  tgt_e             tgt;
  logic [IDX_W-1:0] eidx;
  logic             ehi;
  logic [31:0]      ent_half;
  logic [31:0]      rd_val;
  logic             at_ptr, at_data, tbl_wr;

  assign req_ready = 1'b1;
  assign at_ptr    = req_addr == OFF_PTR;
  assign at_data   = req_addr == OFF_DATA;
  assign tbl_wr    = req_valid && req_write && at_data && tgt == TGT_ENTRY;

  irq_regwin_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dec (
    .ptr(ptr_q), .tgt(tgt), .idx(eidx), .hi(ehi)
  );

  irq_regwin_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst(rst),
    .wr_en(tbl_wr), .wr_idx(eidx), .wr_hi(ehi), .wr_data(req_wdata),
    .sts_wr(sts_wr), .sts_idx(sts_idx), .sts_rirr(sts_rirr), .sts_dstat(sts_dstat),
    .rd_idx(eidx), .rd_hi(ehi), .rd_half(ent_half),
    .mask_chg_valid(mask_chg_valid), .mask_chg_idx(mask_chg_idx)
  );

  always_comb begin
    rd_val = '0;
    if (at_ptr) rd_val = {24'h0, ptr_q};
    else if (at_data) begin
      unique case (tgt)
        TGT_ID, TGT_ARB: rd_val = {4'h0, id_q, 24'h0};
        TGT_VER:         rd_val = VER_WORD;
        TGT_ENTRY:       rd_val = ent_half;
        default:         rd_val = '1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      id_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_rdata <= req_write ? 32'h0 : rd_val;
      if (req_valid && req_write && at_ptr) ptr_q <= req_wdata[7:0];
      if (req_valid && req_write && at_data && tgt == TGT_ID) id_q <= req_wdata[27:24];
    end
  end

  assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_ptr_low_byte_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && at_ptr) |=> ptr_q == $past(req_wdata[7:0]));
  assert_bad_ptr_ones_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && at_data && tgt == TGT_NONE) |=> rsp_rdata == 32'hFFFF_FFFF);
  assert_arb_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && at_data && ptr_q == 8'h02) |=> $stable(id_q));

endmodule

// File: tb/sim_irq_regwin.sv
`timescale 1ns/1ps
module sim_irq_regwin;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        sts_wr = 1'b0, sts_rirr = 1'b0, sts_dstat = 1'b0;
  logic [4:0]  sts_idx = '0;
  logic        mask_chg_valid;
  logic [4:0]  mask_chg_idx;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_regwin u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sts_wr(sts_wr), .sts_idx(sts_idx), .sts_rirr(sts_rirr), .sts_dstat(sts_dstat),
    .mask_chg_valid(mask_chg_valid), .mask_chg_idx(mask_chg_idx)
  );

  // {op(1=read+check,0=write), addr[7:0], data[31:0], expected[31:0]}
  localparam int NV = 36;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'h0, 32'h0000_0000},        // R9 ptr reset
    {1'b0, 8'h00, 32'hABCD_EE01, 32'h0},
    {1'b1, 8'h00, 32'h0, 32'h0000_0001},        // R2
    {1'b1, 8'h10, 32'h0, 32'h0017_0020},        // R3
    {1'b0, 8'h10, 32'hFFFF_FFFF, 32'h0},
    {1'b1, 8'h10, 32'h0, 32'h0017_0020},        // R3 write ignored
    {1'b0, 8'h00, 32'h0000_0000, 32'h0},
    {1'b1, 8'h10, 32'h0, 32'h0000_0000},        // R9 id reset
    {1'b0, 8'h10, 32'h5A00_0000, 32'h0},
    {1'b1, 8'h10, 32'h0, 32'h0A00_0000},        // R4
    {1'b0, 8'h00, 32'h0000_0002, 32'h0},
    {1'b1, 8'h10, 32'h0, 32'h0A00_0000},        // R4 alias
    {1'b0, 8'h10, 32'h0000_0000, 32'h0},
    {1'b1, 8'h10, 32'h0, 32'h0A00_0000},        // R4 alias write ignored
    {1'b0, 8'h00, 32'h0000_0010, 32'h0},
    {1'b1, 8'h10, 32'h0, 32'h0001_0000},        // R9 mask set
    {1'b0, 8'h10, 32'h0000_D0F3, 32'h0},
    {1'b1, 8'h10, 32'h0, 32'h0000_80F3},        // R7 status bits kept
    {1'b0, 8'h00, 32'h0000_0011, 32'h0},
    {1'b0, 8'h10, 32'hC100_0000, 32'h0},
    {1'b1, 8'h10, 32'h0, 32'hC100_0000},        // R5 high half
    {1'b0, 8'h00, 32'h0000_0010, 32'h0},
    {1'b1, 8'h10, 32'h0, 32'h0000_80F3},        // R5 low half untouched
    {1'b0, 8'h00, 32'h0000_003F, 32'h0},
    {1'b1, 8'h10, 32'h0, 32'h0000_0000},        // R5 last entry high
    {1'b0, 8'h00, 32'h0000_003E, 32'h0},
    {1'b1, 8'h10, 32'h0, 32'h0001_0000},        // R5 last entry low
    {1'b0, 8'h00, 32'h0000_0040, 32'h0},
    {1'b0, 8'h10, 32'h0000_0000, 32'h0},
    {1'b1, 8'h10, 32'h0, 32'hFFFF_FFFF},        // R6 beyond pins
    {1'b0, 8'h00, 32'h0000_0005, 32'h0},
    {1'b1, 8'h10, 32'h0, 32'hFFFF_FFFF},        // R6 gap
    {1'b1, 8'h20, 32'h0, 32'h0000_0000},        // R1 other offset
    {1'b0, 8'h20, 32'h1234_5678, 32'h0},
    {1'b1, 8'h00, 32'h0, 32'h0000_0005},        // R1 write ignored
    {1'b0, 8'h00, 32'h0000_0010, 32'h0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus(1'b0, a, 32'h0);
    check(rsp_valid === 1'b1, "R10 rsp_valid", {31'h0, rsp_valid}, 32'h1);
    check(rsp_rdata === exp, tag, rsp_rdata, exp);
  endtask

  task automatic sts(input logic [4:0] i, input bit r, input bit ds);
    @(negedge clk);
    sts_wr = 1'b1; sts_idx = i; sts_rirr = r; sts_dstat = ds;
    @(negedge clk);
    sts_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check(rsp_valid === 1'b0, "R10 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check(mask_chg_valid === 1'b0, "R11 reset pulse", {31'h0, mask_chg_valid}, 32'h0);
    check(req_ready === 1'b1, "R10 ready", {31'h0, req_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) rd_chk(VEC[i][71:64], VEC[i][31:0], $sformatf("vector %0d", i));
      else            bus(1'b1, VEC[i][71:64], VEC[i][63:32]);
    end
    @(negedge clk);
    check(rsp_valid === 1'b0, "R10 single-cycle rsp", {31'h0, rsp_valid}, 32'h0);

    // R12 status port sets hardware bits; R7 they survive a rewrite
    sts(5'd0, 1'b1, 1'b1);
    rd_chk(8'h10, 32'h0000_D0F3, "R12 status load");
    bus(1'b1, 8'h10, 32'h0000_80F4);
    rd_chk(8'h10, 32'h0000_D0F4, "R7 level rewrite keeps bits");
    // R8 switching to edge clears remote-IRR, delivery status kept
    bus(1'b1, 8'h10, 32'h0000_00F4);
    rd_chk(8'h10, 32'h0000_10F4, "R8 edge clears rirr");
    sts(5'd0, 1'b1, 1'b1);
    rd_chk(8'h10, 32'h0000_50F4, "R12 status on edge entry");
    bus(1'b1, 8'h00, 32'h11);
    bus(1'b1, 8'h10, 32'h0);
    bus(1'b1, 8'h00, 32'h10);
    rd_chk(8'h10, 32'h0000_10F4, "R8 high-half write clears rirr");

    // R11 mask notification on entry 2
    bus(1'b1, 8'h00, 32'h14);
    bus(1'b1, 8'h10, 32'h0000_0033);
    check(mask_chg_valid === 1'b1, "R11 unmask pulse", {31'h0, mask_chg_valid}, 32'h1);
    check(mask_chg_idx === 5'd2, "R11 pulse index", {27'h0, mask_chg_idx}, 32'h2);
    @(negedge clk);
    check(mask_chg_valid === 1'b0, "R11 pulse one cycle", {31'h0, mask_chg_valid}, 32'h0);
    bus(1'b1, 8'h10, 32'h0000_0044);
    check(mask_chg_valid === 1'b0, "R11 no pulse same mask", {31'h0, mask_chg_valid}, 32'h0);
    bus(1'b1, 8'h10, 32'h0001_0044);
    check(mask_chg_valid === 1'b1 && mask_chg_idx === 5'd2, "R11 remask pulse",
          {31'h0, mask_chg_valid}, 32'h1);
    bus(1'b1, 8'h00, 32'h15);
    bus(1'b1, 8'h10, 32'hFFFF_FFFF);
    check(mask_chg_valid === 1'b0, "R11 high half no pulse", {31'h0, mask_chg_valid}, 32'h0);

    // R12 collision: status port wins over a same-cycle bus write to entry 5
    bus(1'b1, 8'h00, 32'h1A);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h10; req_wdata = 32'h0000_8000;
    sts_wr = 1'b1; sts_idx = 5'd5; sts_rirr = 1'b1; sts_dstat = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; sts_wr = 1'b0;
    rd_chk(8'h10, 32'h0000_C000, "R12 status wins collision");

    // R9 second reset: all entries masked, id cleared
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    rd_chk(8'h00, 32'h0, "R9 ptr after reset");
    rd_chk(8'h10, 32'h0, "R9 id after reset");
    for (int e = 0; e < 24; e++) begin
      bus(1'b1, 8'h00, 32'(8'h10 + 2 * e));
      rd_chk(8'h10, 32'h0001_0000, $sformatf("R9 entry %0d low", e));
      bus(1'b1, 8'h00, 32'(8'h11 + 2 * e));
      rd_chk(8'h10, 32'h0, $sformatf("R9 entry %0d high", e));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule